// File: doc/BRIEF.md
# Serial-Flash Shadowed Nibble ROM

This block stands in for a small one-time-programmable parallel memory that holds calibration data. Right after reset it runs one SPI read burst against an external serial flash and copies the first 128 bytes into an internal shadow array of 256 four-bit words. Once the copy is complete it raises a ready flag and serves parallel reads from the shadow array. The chip select is then released for good.

The host presents an 8-bit address and an active-low output enable, and it receives a 4-bit nibble. Host reads are slow and asynchronous to the system clock. The address therefore passes through a two-stage synchronizer, and the registered result settles a fixed number of clocks later. The enable acts without delay on a pad-enable output, and the pad ring turns that output into the high-impedance state. A second legacy control input is tied low on the board, and the block ignores it.

Top module: `spi_shadow_rom`

## Requirements
- R1: While reset is asserted and on the first clock after it, `loadDone` is 0, `spiCsN` is 1 and `spiSck` is 0.
- R2: The SPI link runs in mode 0. `spiSck` idles low and has a period of exactly `CLK_DIV` system clocks (default 4). `spiMosi` changes only while `spiSck` is low.
- R3: The first 32 bits shifted out on `spiMosi`, MSB first, are the read command 0x03 followed by a 24-bit start address of zero.
- R4: `spiCsN` stays low for one unbroken burst of exactly 32 + 1024 rising `spiSck` edges. It goes high after the last falling edge and is never asserted again.
- R5: `spiMiso` is sampled on rising `spiSck` edges, MSB first. For data byte k (k = 0..127), bits 7:4 become word 2k and bits 3:0 become word 2k+1.
- R6: While `loadDone` is 0, an enabled read returns 4'hF regardless of the address.
- R7: `loadDone` rises in the same clock in which `spiCsN` is released, and it stays at 1 until reset.
- R8: `romDataEn` is 1 exactly when `romOeN` is 0, with no clock delay. When `romDataEn` is 0, the pad floats.
- R9: After the load, a new address that is held stable appears on `romData` at the third rising clock edge. After two edges the previous word is still shown.
- R10: The legacy input `romAuxN` has no effect on `romData` or `romDataEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSck | output | 1 | SPI serial clock to the flash |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data towards the flash |
| spiMiso | input | 1 | SPI data from the flash |
| romAddr | input | 8 | Parallel read address from the host (asynchronous) |
| romOeN | input | 1 | Output enable from the host, active low |
| romAuxN | input | 1 | Legacy control line, tied low and ignored |
| romData | output | 4 | Read nibble towards the pad |
| romDataEn | output | 1 | Pad output-enable; the pad is high-impedance when 0 |
| loadDone | output | 1 | Shadow array loaded and reads valid |

## Verification
The state that is hardest to reach from the ports is the load window itself. It is short, it happens only once after reset, and it depends on a flash model that follows the block's own SPI clock. The bench therefore uses a behavioural flash that captures the command on rising edges and drives each data bit on falling edges from a computed byte pattern. It probes the pre-load 0xF response inside that window before it waits for the ready flag. After the load, every address is read once. Random address, enable and legacy-line patterns then follow. A directed pair of addresses that hold different nibbles is used to pin the synchronizer latency to exactly three edges.

// File: rtl/shadow_rom_pkg.sv
package shadow_rom_pkg;
  localparam int ADDR_W    = 8;
  localparam int NIB_W     = 4;
  localparam int WORDS     = 2 ** ADDR_W;
  localparam int BYTE_CNT  = WORDS * NIB_W / 8;
  localparam int IDX_W     = $clog2(BYTE_CNT);
  localparam int HDR_BITS  = 32;
  localparam logic [7:0] READ_CMD = 8'h03;

  typedef struct packed {
    logic             txShift;
    logic             rxSample;
    logic             byteWrite;
    logic [IDX_W-1:0] byteIdx;
    logic             loaded;
  } shadowCtl_t;
endpackage

// File: rtl/shadow_rom_ctrl.sv
module shadow_rom_ctrl
  import shadow_rom_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  output shadowCtl_t ctl,
  output logic       spiSck,
  output logic       spiCsN
);
  localparam int LOW_CYC    = CLK_DIV - CLK_DIV / 2;
  localparam int DIV_W      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int TOTAL_BITS = HDR_BITS + BYTE_CNT * 8;
  localparam int BIT_W      = $clog2(TOTAL_BITS + 1);

  typedef enum logic [1:0] {ST_START, ST_XFER, ST_DONE} loadState_t;

  loadState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             riseTick;
  logic             fallTick;
  logic [BIT_W-1:0] dataBit;

  assign riseTick = (state == ST_XFER) && (divCnt == DIV_W'(LOW_CYC - 1));
  assign fallTick = (state == ST_XFER) && (divCnt == DIV_W'(CLK_DIV - 1));
  assign dataBit  = bitCnt - BIT_W'(HDR_BITS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_START;
      spiCsN <= 1'b1;
      spiSck <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_START: begin
          spiCsN <= 1'b0;
          state  <= ST_XFER;
        end
        ST_XFER: begin
          if (fallTick) begin
            divCnt <= '0;
            spiSck <= 1'b0;
            if (bitCnt == BIT_W'(TOTAL_BITS - 1)) begin
              state  <= ST_DONE;
              spiCsN <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
            if (riseTick) spiSck <= 1'b1;
          end
        end
        default: begin
          spiCsN <= 1'b1;
          spiSck <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    ctl.txShift   = fallTick;
    ctl.rxSample  = riseTick;
    ctl.byteWrite = riseTick && (bitCnt >= BIT_W'(HDR_BITS)) && (bitCnt[2:0] == 3'd7);
    ctl.byteIdx   = IDX_W'(dataBit >> 3);
    ctl.loaded    = (state == ST_DONE);
  end
endmodule

// File: rtl/shadow_rom_datapath.sv
module shadow_rom_datapath
  import shadow_rom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  shadowCtl_t        ctl,
  input  logic              spiMiso,
  output logic              spiMosi,
  input  logic [ADDR_W-1:0] romAddr,
  input  logic              romOeN,
  output logic [NIB_W-1:0]  romData,
  output logic              romDataEn
);
  logic [HDR_BITS-1:0] txReg;
  logic [6:0]          rxReg;
  logic [7:0]          rxByte;
  logic [NIB_W-1:0]    shadowMem [WORDS];
  logic [ADDR_W-1:0]   addrSync [SYNC_STAGES];
  logic [NIB_W-1:0]    dataReg;

  assign spiMosi = txReg[HDR_BITS-1];
  assign rxByte  = {rxReg, spiMiso};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg <= {READ_CMD, {(HDR_BITS-8){1'b0}}};
      rxReg <= '0;
    end else begin
      if (ctl.txShift)  txReg <= txReg << 1;
      if (ctl.rxSample) rxReg <= rxByte[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.byteWrite) begin
      shadowMem[{ctl.byteIdx, 1'b0}] <= rxByte[7:4];
      shadowMem[{ctl.byteIdx, 1'b1}] <= rxByte[3:0];
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN)       addrSync[s] <= '0;
      else if (s == 0) addrSync[s] <= romAddr;
      else             addrSync[s] <= addrSync[(s > 0) ? s - 1 : 0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else       dataReg <= shadowMem[addrSync[SYNC_STAGES-1]];
  end

  assign romData   = ctl.loaded ? dataReg : {NIB_W{1'b1}};
  assign romDataEn = !romOeN;
endmodule

// File: rtl/spi_shadow_rom.sv
module spi_shadow_rom
  import shadow_rom_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              spiSck,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso,
  input  logic [ADDR_W-1:0] romAddr,
  input  logic              romOeN,
  input  logic              romAuxN,
  output logic [NIB_W-1:0]  romData,
  output logic              romDataEn,
  output logic              loadDone
);
  shadowCtl_t ctl;
  logic       unusedAux;

  assign unusedAux = romAuxN;
  assign loadDone  = ctl.loaded;

  shadow_rom_ctrl #(.CLK_DIV(CLK_DIV)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .spiSck (spiSck),
    .spiCsN (spiCsN)
  );

  shadow_rom_datapath #(.SYNC_STAGES(2)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .spiMiso   (spiMiso),
    .spiMosi   (spiMosi),
    .romAddr   (romAddr),
    .romOeN    (romOeN),
    .romData   (romData),
    .romDataEn (romDataEn)
  );
endmodule

// File: rtl/shadow_rom_checker.sv
module shadow_rom_checker (
  input logic       clk,
  input logic       rstN,
  input logic       spiSck,
  input logic       spiCsN,
  input logic       spiMosi,
  input logic       romOeN,
  input logic [3:0] romData,
  input logic       romDataEn,
  input logic       loadDone
);
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && $past(spiSck)) |-> $stable(spiMosi));

  assert_sck_in_burst_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSck) |-> !spiCsN);

  assert_blank_before_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!loadDone && romDataEn) |-> (romData == 4'hF));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  assert_done_bus_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (spiCsN && !spiSck));

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    romOeN |-> !romDataEn);
endmodule

bind spi_shadow_rom shadow_rom_checker i_chk (.*);

// File: tb/test_spi_shadow_rom.sv
module test_spi_shadow_rom;
  localparam int CLK_DIV = 4;
  localparam realtime TCLK = 5ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiSck, spiCsN, spiMosi;
  logic       spiMiso = 1'b0;
  logic [7:0] romAddr = 8'd0;
  logic       romOeN = 1'b1;
  logic       romAuxN = 1'b0;
  logic [3:0] romData;
  logic       romDataEn;
  logic       loadDone;

  int total = 0;
  int bad = 0;

  always #(TCLK / 2) clk = ~clk;

  spi_shadow_rom #(.CLK_DIV(CLK_DIV)) i_spi_shadow_rom (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .romAddr(romAddr), .romOeN(romOeN), .romAuxN(romAuxN),
    .romData(romData), .romDataEn(romDataEn), .loadDone(loadDone)
  );

  function automatic logic [7:0] flashByte(int k);
    return 8'((k * 73 + 29) ^ (k >> 1) ^ 8'h5A);
  endfunction

  function automatic logic [3:0] expNib(logic [7:0] a);
    logic [7:0] b;
    b = flashByte(int'(a >> 1));
    return a[0] ? b[3:0] : b[7:4];
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // behavioural flash
  logic [31:0] cmdCap = '0;
  int riseCnt = 0;
  int csFalls = 0;
  int periodErr = 0;
  realtime lastRise = 0;

  always @(negedge spiCsN) begin
    csFalls++;
    riseCnt = 0;
  end

  always @(posedge spiSck) begin
    if (riseCnt > 0 && ($realtime - lastRise) != CLK_DIV * TCLK) periodErr++;
    lastRise = $realtime;
    if (riseCnt < 32) cmdCap = {cmdCap[30:0], spiMosi};
    riseCnt++;
  end

  always @(negedge spiSck) begin
    if (!spiCsN && riseCnt >= 32) begin
      int idx;
      logic [7:0] b;
      idx = riseCnt - 32;
      b = flashByte(idx / 8);
      spiMiso = b[7 - (idx % 8)];
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(loadDone == 1'b0 && spiCsN == 1'b1 && spiSck == 1'b0, "R1 reset outputs",
          {loadDone, spiCsN, spiSck}, 3'b010);
    rstN = 1'b1;
    @(negedge clk);
    check(loadDone == 1'b0 && spiSck == 1'b0, "R1 first clock after reset",
          {loadDone, spiSck}, 2'b00);
    // R6 / R8 before the load completes
    romOeN = 1'b0;
    romAddr = 8'h37;
    repeat (5) @(negedge clk);
    check(romDataEn == 1'b1, "R8 enable while loading", romDataEn, 1);
    check(romData == 4'hF, "R6 blank nibble during load", romData, 4'hF);
    romAddr = 8'h80;
    repeat (4) @(negedge clk);
    check(romData == 4'hF, "R6 blank nibble other address", romData, 4'hF);
    romOeN = 1'b1;
    #1;
    check(romDataEn == 1'b0, "R8 float while loading", romDataEn, 0);

    // wait for the load
    for (int i = 0; i < 20000 && !loadDone; i++) @(negedge clk);
    check(loadDone == 1'b1, "R7 load completes", loadDone, 1);
    check(spiCsN == 1'b1, "R7 chip select released with ready", spiCsN, 1);
    check(cmdCap == 32'h0300_0000, "R3 command and address", cmdCap, 32'h0300_0000);
    check(riseCnt == 32 + 1024, "R4 burst length", riseCnt, 1056);
    check(csFalls == 1, "R4 single burst", csFalls, 1);
    check(periodErr == 0, "R2 sck period", periodErr, 0);
    repeat (50) @(negedge clk);
    check(loadDone == 1'b1 && spiCsN == 1'b1 && csFalls == 1, "R7 ready sticky, no new burst",
          {loadDone, spiCsN}, 2'b11);

    // R5 every word
    romOeN = 1'b0;
    for (int a = 0; a < 256; a++) begin
      romAddr = 8'(a);
      repeat (3) @(negedge clk);
      check(romData == expNib(8'(a)) && romDataEn, $sformatf("R5 word %0d", a),
            romData, expNib(8'(a)));
    end

    // R9 latency, two addresses with different nibbles
    begin
      logic [7:0] pa, pb;
      pa = 8'h10;
      pb = 8'h11;
      for (int j = 0; j < 256; j++)
        if (expNib(8'(j)) != expNib(pa)) pb = 8'(j);
      romAddr = pa;
      repeat (4) @(negedge clk);
      romAddr = pb;
      repeat (2) @(negedge clk);
      check(romData == expNib(pa), "R9 old word after two edges", romData, expNib(pa));
      @(negedge clk);
      check(romData == expNib(pb), "R9 new word at third edge", romData, expNib(pb));
    end

    // R10 legacy line toggling while holding an address
    romAddr = 8'hC3;
    repeat (3) @(negedge clk);
    for (int t = 0; t < 6; t++) begin
      romAuxN = ~romAuxN;
      @(negedge clk);
      check(romData == expNib(8'hC3) && romDataEn, "R10 aux toggle ignored",
            romData, expNib(8'hC3));
    end
    romAuxN = 1'b0;

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ra;
      ra = 8'($urandom);
      romAddr = ra;
      romOeN = 1'($urandom);
      romAuxN = 1'($urandom);
      repeat (3) @(negedge clk);
      check(romDataEn == !romOeN, "R8 random enable", romDataEn, !romOeN);
      check(romData == expNib(ra), "R5 R10 random read", romData, expNib(ra));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule